// File: doc/BRIEF.md
# Split-Transfer Register-File Bus Slave

This block is a bus target backed by a small register file. Every transfer has two phases, and each phase gets its own handshake. The address phase ends when the slave answers the master's address strobe with an address acknowledge. The data phase ends later, either with a write acknowledge or with read data plus a read acknowledge. This lets the master release the address lines early, while the data side of the same transfer is still in progress.

The master raises `addr_valid` and holds the address, the direction (`rd_not_wr`) and the latency select (`lat_sel`) until it sees `addr_ack`. For a write, the master keeps `wr_data` stable until it sees `wr_ack`. The slave samples the write word on the clock edge that ends the `addr_ack` cycle. For a read, the slave returns the word after a latency chosen per transfer, from one to `MAX_LAT` cycles. Only one transfer can be open at a time.

All inputs are sampled on the rising edge of `clk`. Reset is active low and synchronous.

Top module: `split_xfer_slave`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `addr_ack`, `wr_ack` and `rd_ack` are low and `rd_data` is zero.
- R2: When the slave is idle and samples `addr_valid` high on a rising edge, `addr_ack` is high for exactly the next cycle and then low.
- R3: For a write (`rd_not_wr` = 0), `wr_ack` is high for exactly the one cycle that follows the `addr_ack` cycle. The word stored at the captured address is the `wr_data` value present at the edge that raises `wr_ack`.
- R4: For a read (`rd_not_wr` = 1), `rd_ack` is high for exactly one cycle, `lat_sel`+1 cycles after the `addr_ack` cycle (`lat_sel` = 0 gives 1 cycle, 3 gives 4). In that cycle `rd_data` holds the stored word.
- R5: `rd_data` is all zeros in every cycle in which `rd_ack` is low.
- R6: Only one transfer can be outstanding. An `addr_valid` raised while a transfer is open gets no `addr_ack` until the data acknowledge of the open transfer has ended. With a held request, `addr_ack` comes in the second cycle after the data acknowledge cycle. At most one of the three acknowledges is high in any cycle.
- R7: `lat_sel` is captured with the address. Changing it after the address phase has no effect on the latency of that read.
- R8: With `RESET_MEM` = 1 (the default), reset clears every register-file word to zero.
- R9: A read leaves the stored word unchanged, and a write produces no `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_valid | input | 1 | Master address strobe |
| rd_not_wr | input | 1 | 1 = read, 0 = write; sampled with the address |
| addr | input | ADDR_W | Word address |
| lat_sel | input | SEL_W | Read latency minus one; sampled with the address |
| wr_data | input | DATA_W | Write word; sampled at the edge ending the `addr_ack` cycle |
| addr_ack | output | 1 | Address phase acknowledge |
| wr_ack | output | 1 | Write data acknowledge |
| rd_ack | output | 1 | Read data acknowledge |
| rd_data | output | DATA_W | Read word; zero unless `rd_ack` is high |

## Verification
The checker assumes that the master holds `addr_valid` until it observes `addr_ack`, and that no master ever expects two acknowledges in the same cycle. Its read-latency window is counted from the most recent `addr_ack`, which is only meaningful when a single transfer is open. The bench drives all inputs on the falling edge and drops `addr_valid` in the `addr_ack` cycle. It raises a second request during an open read only to show that the request is held off, and it keeps `wr_data` steady from the `addr_ack` cycle until `wr_ack`.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ADDR  = 3'd1,
      PH_WDATA = 3'd2,
      PH_WAIT  = 3'd3,
      PH_RDATA = 3'd4
   } sxs_phase_e;

   function automatic int sel_width(input int max_lat);
      return (max_lat > 1) ? $clog2(max_lat) : 1;
   endfunction
endpackage

// File: rtl/sxs_regfile.sv
module sxs_regfile #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter bit RESET_MEM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   generate
      if (RESET_MEM) begin : g_rst_mem
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            end else if (we) begin
               words[waddr] <= wdata;
            end
         end
      end else begin : g_plain_mem
         always_ff @(posedge clk) begin
            if (we) words[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = words[raddr];
endmodule

// File: rtl/sxs_phase_ctrl.sv
module sxs_phase_ctrl
   import sxs_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int MAX_LAT = 4,
   parameter int SEL_W   = sel_width(MAX_LAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_valid,
   input  logic              rd_not_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEL_W-1:0]  lat_sel,
   output logic              addr_ack,
   output logic              wr_ack,
   output logic              rd_ack,
   output logic              mem_we,
   output logic              rd_load,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam logic [SEL_W-1:0] LAT_TOP = SEL_W'(MAX_LAT - 1);

   sxs_phase_e       phase_q, phase_d;
   logic             rnw_q;
   logic [SEL_W-1:0] lat_q, cnt_q, cnt_d;
   logic [SEL_W-1:0] lat_clamped;

   assign lat_clamped = (lat_sel > LAT_TOP) ? LAT_TOP : lat_sel;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      unique case (phase_q)
         PH_IDLE:  if (addr_valid) phase_d = PH_ADDR;
         PH_ADDR: begin
            if (!rnw_q) begin
               phase_d = PH_WDATA;
            end else if (lat_q == '0) begin
               phase_d = PH_RDATA;
            end else begin
               phase_d = PH_WAIT;
               cnt_d   = lat_q;
            end
         end
         PH_WAIT: begin
            if (cnt_q == SEL_W'(1)) phase_d = PH_RDATA;
            else                    cnt_d   = cnt_q - SEL_W'(1);
         end
         PH_WDATA: phase_d = PH_IDLE;
         PH_RDATA: phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         lat_q    <= '0;
         rnw_q    <= 1'b0;
         cur_addr <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         if (phase_q == PH_IDLE && addr_valid) begin
            lat_q    <= lat_clamped;
            rnw_q    <= rd_not_wr;
            cur_addr <= addr;
         end
      end
   end

   assign addr_ack = (phase_q == PH_ADDR);
   assign wr_ack   = (phase_q == PH_WDATA);
   assign rd_ack   = (phase_q == PH_RDATA);
   assign mem_we   = (phase_q == PH_ADDR) && !rnw_q;
   assign rd_load  = (phase_d == PH_RDATA) && (phase_q != PH_RDATA);
endmodule

// File: rtl/sxs_rdata_stage.sv
module sxs_rdata_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk) begin
      if (!rst_n)    rd_data <= '0;
      else if (load) rd_data <= word;
      else           rd_data <= '0;
   end
endmodule

// File: rtl/split_xfer_slave.sv
module split_xfer_slave
   import sxs_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int MAX_LAT   = 4,
   parameter bit RESET_MEM = 1'b1,
   parameter int SEL_W     = sel_width(MAX_LAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_valid,
   input  logic              rd_not_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEL_W-1:0]  lat_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              addr_ack,
   output logic              wr_ack,
   output logic              rd_ack,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
         $error("split_xfer_slave: ADDR_W must lie in 1..10");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("split_xfer_slave: DATA_W must be positive");
      end
      if (MAX_LAT < 1 || (1 << SEL_W) < MAX_LAT) begin : g_bad_lat
         $error("split_xfer_slave: MAX_LAT must be >= 1 and fit in SEL_W");
      end
   endgenerate

   logic              mem_we;
   logic              rd_load;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] mem_word;

   sxs_phase_ctrl #(
      .ADDR_W (ADDR_W),
      .MAX_LAT(MAX_LAT),
      .SEL_W  (SEL_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_valid(addr_valid),
      .rd_not_wr (rd_not_wr),
      .addr      (addr),
      .lat_sel   (lat_sel),
      .addr_ack  (addr_ack),
      .wr_ack    (wr_ack),
      .rd_ack    (rd_ack),
      .mem_we    (mem_we),
      .rd_load   (rd_load),
      .cur_addr  (cur_addr)
   );

   sxs_regfile #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RESET_MEM(RESET_MEM)
   ) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mem_we),
      .waddr(cur_addr),
      .wdata(wr_data),
      .raddr(cur_addr),
      .rdata(mem_word)
   );

   sxs_rdata_stage #(
      .DATA_W(DATA_W)
   ) u_rdata (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (rd_load),
      .word   (mem_word),
      .rd_data(rd_data)
   );
endmodule

// File: rtl/sxs_checker.sv
module sxs_checker #(
   parameter int DATA_W  = 32,
   parameter int MAX_LAT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_valid,
   input logic              addr_ack,
   input logic              wr_ack,
   input logic              rd_ack,
   input logic [DATA_W-1:0] rd_data
);
   logic [15:0] since_aack;

   always_ff @(posedge clk) begin
      if (!rst_n)                  since_aack <= '0;
      else if (addr_ack)           since_aack <= 16'd1;
      else if (since_aack != '0 && since_aack != 16'hFFFF)
                                   since_aack <= since_aack + 16'd1;
   end

   a_r2_aack_single: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ack |=> !addr_ack);

   a_r2_aack_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_ack) |-> $past(addr_valid));

   a_r3_wack_follows_aack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |-> $past(addr_ack));

   a_r3_wack_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> !wr_ack);

   a_r4_rack_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |=> !rd_ack);

   a_r4_rack_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |-> (since_aack >= 16'd1 && since_aack <= 16'(MAX_LAT)));

   a_r5_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ack |-> (rd_data == '0));

   a_r6_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_ack, wr_ack, rd_ack}));
endmodule

bind split_xfer_slave sxs_checker #(
   .DATA_W (DATA_W),
   .MAX_LAT(MAX_LAT)
) u_sxs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_valid(addr_valid),
   .addr_ack  (addr_ack),
   .wr_ack    (wr_ack),
   .rd_ack    (rd_ack),
   .rd_data   (rd_data)
);

// File: tb/split_xfer_slave_test.sv
`timescale 1ns/1ps
module split_xfer_slave_test;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          addr_valid = 1'b0;
   logic          rd_not_wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [SW-1:0] lat_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic          addr_ack, wr_ack, rd_ack;
   logic [DW-1:0] rd_data;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   split_xfer_slave uut (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .rd_not_wr(rd_not_wr),
      .addr(addr), .lat_sel(lat_sel), .wr_data(wr_data),
      .addr_ack(addr_ack), .wr_ack(wr_ack), .rd_ack(rd_ack), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic address_phase(input bit rnw, input logic [AW-1:0] a,
                                input logic [SW-1:0] lat, input string req);
      int waitc = 0;
      @(negedge clk);
      addr_valid = 1'b1; rd_not_wr = rnw; addr = a; lat_sel = lat;
      do begin
         @(negedge clk);
         waitc++;
      end while (!addr_ack && waitc < 50);
      chk(waitc == 1, req, waitc, 1);
      addr_valid = 1'b0;
      addr = ~a;
      lat_sel = ~lat;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_data = ~d;
      address_phase(1'b0, a, 2'd0, "R2 addr_ack delay");
      wr_data = d;                       // R3: word sampled at edge ending addr_ack cycle
      @(negedge clk);
      chk(wr_ack && !addr_ack, "R3 wr_ack after addr_ack", {wr_ack, addr_ack}, 2'b10);
      chk(!rd_ack, "R9 no rd_ack on write", rd_ack, 0);
      @(negedge clk);
      chk(!wr_ack && !addr_ack, "R2/R3 single-cycle acks", {wr_ack, addr_ack}, 0);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [SW-1:0] lat,
                          input logic [DW-1:0] exp);
      int n = 0;
      address_phase(1'b1, a, lat, "R2 addr_ack delay");
      do begin
         @(negedge clk);
         n++;
         if (!rd_ack) chk(rd_data == '0, "R5 rd_data zero while idle", rd_data, 0);
      end while (!rd_ack && n < 12);
      chk(n == int'(lat) + 1, "R4/R7 read latency", n, int'(lat) + 1);
      chk(rd_data == exp, "R4 read word", rd_data, exp);
      @(negedge clk);
      chk(!rd_ack && rd_data == '0, "R4/R5 rd_ack single and data cleared",
          {rd_ack, rd_data}, 0);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      chk({addr_ack, wr_ack, rd_ack} == 3'b000, "R1 acks low in reset",
          {addr_ack, wr_ack, rd_ack}, 0);
      chk(rd_data == '0, "R1 rd_data zero in reset", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({addr_ack, wr_ack, rd_ack} == 3'b000 && rd_data == '0,
          "R1 quiet after reset", {addr_ack, wr_ack, rd_ack}, 0);
   endtask

   task automatic test_busy();
      int n = 0;
      address_phase(1'b1, 4'd3, 2'd3, "R2 addr_ack delay");
      addr_valid = 1'b1; rd_not_wr = 1'b0; addr = 4'd9; wr_data = 32'h0BAD_F00D;
      do begin
         @(negedge clk);
         n++;
         if (!rd_ack) chk(!addr_ack, "R6 no addr_ack while open", addr_ack, 0);
      end while (!rd_ack && n < 12);
      chk(n == 4, "R6 open read latency", n, 4);
      chk(rd_data == 32'hA5A5_0003, "R6 open read word", rd_data, 32'hA5A5_0003);
      @(negedge clk);
      chk(!addr_ack, "R6 addr_ack not yet", addr_ack, 0);
      @(negedge clk);
      chk(addr_ack, "R6 held request accepted", addr_ack, 1);
      addr_valid = 1'b0;
      @(negedge clk);
      chk(wr_ack, "R6 queued write acked", wr_ack, 1);
      @(negedge clk);
      do_read(4'd9, 2'd0, 32'h0BAD_F00D);
   endtask

   initial begin
      test_reset();
      do_read(4'd5, 2'd0, 32'h0);                       // R8 cleared contents
      do_write(4'd3, 32'hA5A5_0003);
      do_write(4'd12, 32'h1234_5678);
      do_read(4'd3, 2'd0, 32'hA5A5_0003);               // R4 latency 1
      do_read(4'd12, 2'd1, 32'h1234_5678);              // R4 latency 2
      do_read(4'd12, 2'd2, 32'h1234_5678);              // R4 latency 3, R9 unchanged
      do_read(4'd3, 2'd3, 32'hA5A5_0003);               // R4 latency 4
      do_write(4'd3, 32'hFFFF_0000);                    // R3 overwrite
      do_read(4'd3, 2'd1, 32'hFFFF_0000);
      do_write(4'd3, 32'hA5A5_0003);
      test_busy();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule